// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block collects event pulses from the transmit and receive engines of an Ethernet MAC into a 32-bit interrupt status register and gates them with a 32-bit interrupt enable register. Receive events occupy the lower half-word of the status register and transmit events the upper half-word. Each half carries a summary bit that the block derives from that half's masked error and completion sources. The block drives one transmit and one receive interrupt line from those summaries.

Software reads either register through a selectable read port. It writes the enable register directly and clears status bits by writing ones. A synchronous soft reset returns both registers and both lines to zero. Each interrupt line is a small two-state machine. LINE_LOW moves to LINE_HIGH when the gated summary level is high (transition ASSERT). LINE_HIGH returns to LINE_LOW when that level falls or a soft reset arrives (transition DEASSERT). Otherwise each state holds (transition HOLD).

Top module: `mac_irq_agg`

## Requirements
- R1: After the asynchronous reset (rst_n low), the status register, the enable register, irq_tx and irq_rx all read zero.
- R2: A one on evt_set[i] sets status bit i at the next rising edge, and the bit stays set until it is cleared. Event ones at the summary positions (bit 0 and bit 16) have no effect on the status register.
- R3: A write with wr_sel=0 clears every status bit whose wr_data bit is one. Status bits written as zero keep their value.
- R4: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: A write with wr_sel=1 stores all 32 bits of wr_data in the enable register. The register reads back with rd_sel=1, and the status register reads with rd_sel=0.
- R6: Status bit 16 (TX summary) equals the OR over bits 17 (TX complete), 18 (TX descriptor unavailable) and 19 (TX bus error) of status AND enable. It takes its new value at the same edge as any status or enable change.
- R7: Status bit 0 (RX summary) equals the OR over bits 1 (RX good), 2 (RX descriptor unavailable) and 3 (RX bus error) of status AND enable. It is recomputed on events, on clearing writes and on enable writes.
- R8: irq_tx equals status[16] AND enable[16], and irq_rx equals status[0] AND enable[0]. Each line follows one rising edge after the registers change.
- R9: soft_rst high at a rising edge clears status and enable and drives both interrupt lines low at that same edge. It overrides any write or event in that cycle.
- R10: Status bits outside the six source and two summary positions latch events but never affect either summary or either line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of registers and lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 enable |
| rd_data | output | 32 | Selected register contents |
| evt_set | input | 32 | Event pulses, one per status bit |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
Status and enable contents, including both summary bits, change at the first rising edge after an event, write or soft reset. The interrupt lines change one rising edge later, except under soft reset, where they fall at the same edge. The bench drives every stimulus on a falling edge and removes it on the next falling edge. At that point it reads the registers. For a line it waits one more falling edge, and it also samples the line at the earlier point, where the old value must still show.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    localparam int REG_W   = 32;
    localparam int N_HALF  = 2;            // index 0: receive, 1: transmit
    localparam int HALF_RX = 0;
    localparam int HALF_TX = 1;

    // Summary bit position of each half
    localparam int SUM_POS [N_HALF] = '{0, 16};

    // Sources that feed each half's summary (good/complete, descriptor unavailable, bus error)
    localparam logic [REG_W-1:0] SRC_MASK [N_HALF] = '{32'h0000_000E, 32'h000E_0000};

    localparam logic [REG_W-1:0] SUM_MASK = 32'h0001_0001;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;
endpackage

// File: rtl/mac_irq_summary.sv
module mac_irq_summary
    import mac_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] SOURCES = '0
) (
    input  logic [REG_W-1:0] stat_i,
    input  logic [REG_W-1:0] en_i,
    output logic             sum_o
);
    always_comb begin
        sum_o = |(stat_i & en_i & SOURCES);
    end
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_stat,
    input  logic             wr_en_reg,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] evt_set,
    input  logic [N_HALF-1:0] sum_i,
    output logic [REG_W-1:0] stat_pre_o,
    output logic [REG_W-1:0] en_nx_o,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] en_q
);
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] stat_d;

    always_comb begin
        clr_vec = wr_stat ? wr_data : '0;
        if (soft_rst) begin
            stat_pre_o = '0;
            en_nx_o    = '0;
        end else begin
            // events are merged after the clear so a same-cycle event survives
            stat_pre_o = ((stat_q & ~clr_vec) | evt_set) & ~SUM_MASK;
            en_nx_o    = wr_en_reg ? wr_data : en_q;
        end
    end

    always_comb begin
        stat_d = stat_pre_o;
        for (int h = 0; h < N_HALF; h++) begin
            stat_d[SUM_POS[h]] = sum_i[h];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            en_q   <= en_nx_o;
        end
    end

    // R4: an event bit outside the summary positions is set after the edge, whatever was written
    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((stat_q & $past(evt_set & ~SUM_MASK)) == $past(evt_set & ~SUM_MASK)));

    // R3: bits written as one without a coincident event are clear after the edge
    a_r3_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !soft_rst) |=> ((stat_q & $past(wr_data & ~evt_set & ~SUM_MASK)) == '0));

    // R9: soft reset empties both registers
    a_r9_soft_clears_regs: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (stat_q == '0 && en_q == '0));
endmodule

// File: rtl/mac_irq_line.sv
module mac_irq_line
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic level_i,
    output logic irq_o
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (level_i && !soft_rst) state_d = LINE_HIGH;
            LINE_HIGH: if (!level_i || soft_rst) state_d = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == LINE_HIGH);
    end

    // R8: the line shows the gated summary one edge later
    a_r8_line_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (irq_o == $past(level_i)));

    // R9: soft reset forces the line low
    a_r9_soft_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq_o);
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
    import mac_irq_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] evt_set,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic [REG_W-1:0]  stat_pre, en_nx, stat_q, en_q;
    logic [N_HALF-1:0] sum_nx;
    logic [N_HALF-1:0] irq_vec;

    mac_irq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_stat    (wr_en && !wr_sel),
        .wr_en_reg  (wr_en && wr_sel),
        .wr_data    (wr_data),
        .evt_set    (evt_set),
        .sum_i      (sum_nx),
        .stat_pre_o (stat_pre),
        .en_nx_o    (en_nx),
        .stat_q     (stat_q),
        .en_q       (en_q)
    );

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        mac_irq_summary #(.SOURCES(SRC_MASK[h])) u_sum (
            .stat_i (stat_pre),
            .en_i   (en_nx),
            .sum_o  (sum_nx[h])
        );

        mac_irq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .level_i  (stat_q[SUM_POS[h]] & en_q[SUM_POS[h]]),
            .irq_o    (irq_vec[h])
        );
    end

    always_comb begin
        rd_data = rd_sel ? en_q : stat_q;
        irq_tx  = irq_vec[HALF_TX];
        irq_rx  = irq_vec[HALF_RX];
    end

    // R6: stored TX summary matches its masked sources
    a_r6_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[SUM_POS[HALF_TX]] == |(stat_q & en_q & SRC_MASK[HALF_TX]));

    // R7: stored RX summary matches its masked sources
    a_r7_rx_summary: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[SUM_POS[HALF_RX]] == |(stat_q & en_q & SRC_MASK[HALF_RX]));
endmodule

// File: tb/mac_irq_agg_bench.sv
module mac_irq_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] evt_set = '0;
    logic        irq_tx, irq_rx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mac_irq_agg u_mac_irq_agg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .evt_set(evt_set),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 status after reset", v, 32'h0);
        rd(1'b1, v); chk("R1 enable after reset", v, 32'h0);
        chk("R1 irq_tx after reset", {31'b0, irq_tx}, 32'h0);
        chk("R1 irq_rx after reset", {31'b0, irq_rx}, 32'h0);
    endtask

    task automatic t_tx_path();
        logic [31:0] v;
        wr(1'b1, 32'h0003_0000);
        pulse(32'h0002_0000);
        rd(1'b0, v); chk("R2 R6 tx complete sets source and summary", v, 32'h0003_0000);
        chk("R8 irq_tx not yet raised", {31'b0, irq_tx}, 32'h0);
        @(negedge clk);
        chk("R8 irq_tx raised one edge later", {31'b0, irq_tx}, 32'h1);
        chk("R8 irq_rx stays low", {31'b0, irq_rx}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(1'b0, 32'h0002_0000);
        rd(1'b0, v); chk("R3 R6 clear drops source and summary", v, 32'h0);
        chk("R8 irq_tx still high for one edge", {31'b0, irq_tx}, 32'h1);
        @(negedge clk);
        chk("R8 irq_tx falls after clear", {31'b0, irq_tx}, 32'h0);
        pulse(32'h0000_0030);
        rd(1'b0, v); chk("R10 plain event bits latch without summary", v, 32'h0000_0030);
        @(negedge clk);
        chk("R10 plain event bits raise no line", {31'b0, irq_rx}, 32'h0);
        wr(1'b0, 32'h0000_0010);
        rd(1'b0, v); chk("R3 zero-written bits keep value", v, 32'h0000_0020);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0020; evt_set = 32'h0000_0060;
        @(negedge clk);
        wr_en = 1'b0; evt_set = '0;
        rd(1'b0, v); chk("R4 event wins over same-cycle clear", v, 32'h0000_0060);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R3 full clear", v, 32'h0);
        wr(1'b1, 32'h0000_0005);
        pulse(32'h0000_0002);
        rd(1'b0, v); chk("R7 unenabled rx good gives no summary", v, 32'h0000_0002);
        pulse(32'h0000_0004);
        rd(1'b0, v); chk("R7 enabled descriptor unavailable sets summary", v, 32'h0000_0007);
        @(negedge clk);
        chk("R8 irq_rx raised", {31'b0, irq_rx}, 32'h1);
        wr(1'b1, 32'h0000_0004);
        rd(1'b0, v); chk("R7 summary kept while source enabled", v, 32'h0000_0007);
        @(negedge clk);
        chk("R8 irq_rx falls with summary enable off", {31'b0, irq_rx}, 32'h0);
        wr(1'b1, 32'h0000_0001);
        rd(1'b0, v); chk("R7 enable write recomputes summary", v, 32'h0000_0006);
        pulse(32'h0001_0001);
        rd(1'b0, v); chk("R2 events at summary positions ignored", v, 32'h0000_0006);
    endtask

    task automatic t_en_rb();
        logic [31:0] v;
        wr(1'b1, 32'hA5A5_5A5A);
        rd(1'b1, v); chk("R5 enable read back", v, 32'hA5A5_5A5A);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        wr(1'b1, 32'h0003_0000);
        pulse(32'h0002_0000);
        @(negedge clk);
        chk("R8 irq_tx high before soft reset", {31'b0, irq_tx}, 32'h1);
        @(negedge clk);
        soft_rst = 1'b1; evt_set = 32'h0002_0100;
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        soft_rst = 1'b0; evt_set = '0; wr_en = 1'b0;
        rd(1'b0, v); chk("R9 status cleared", v, 32'h0);
        rd(1'b1, v); chk("R9 enable cleared", v, 32'h0);
        chk("R9 irq_tx low at same edge", {31'b0, irq_tx}, 32'h0);
        chk("R9 irq_rx low", {31'b0, irq_rx}, 32'h0);
        @(negedge clk);
        chk("R9 irq_tx stays low", {31'b0, irq_tx}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_path();
        t_w1c();
        t_prio();
        t_rx();
        t_en_rb();
        t_soft();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule